// File: doc/BRIEF.md
# Pipelined Bus Cycle Issue Controller

This block takes requests from an internal queue and starts cycles on an external processor-style bus. Each request carries an address, a memory-or-I/O flag, a read/write flag and a burst flag. The controller holds one accepted request at a time. It starts a bus cycle by driving the active-low address strobe `ads_n` for one clock. In that same clock it places the address and the cycle definition (`bus_mem`, `bus_wr`) on the bus.

The external system can tell the controller to start the next cycle early by pulling `nxt_n` low. This is allowed while the data phase of the current cycle is still running. The early cycle starts a fixed two clocks after `nxt_n` is sampled. At most two cycles are ever in flight. Completion is counted on `brdy_n`. A single cycle needs one beat and a burst cycle needs `BURST_LEN` beats. Each beat applies to the oldest cycle in flight. When the pipeline is full, or a request is already waiting, `req_ready` goes low to hold off the requester.

Top module: `bus_cycle_issuer`

## Requirements
- R1: While `rst_n` is low and after it is released, `ads_n` is 1, `req_ready` is 1 and `bus_addr`, `bus_mem`, `bus_wr` are 0, until the first request is accepted.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. If no cycle is in flight, `ads_n` goes low at the next rising edge.
- R3: `ads_n` is low for exactly one clock for each cycle started.
- R4: At the edge where `ads_n` goes low, `bus_addr`, `bus_mem` (1 = memory, 0 = I/O) and `bus_wr` (1 = write) take the request's values. They keep those values until the next `ads_n`.
- R5: An early-start token is taken when `nxt_n` is sampled low with all of these true: one to `MAX_OUT-1` cycles are in flight, `ads_n` is high, and no token is already held. If a request is waiting at the second rising edge after the sampling edge, its `ads_n` goes low at that edge. Otherwise it goes low at the first edge where a request is waiting.
- R6: A cycle needs 1 beat when `req_burst` is 0 and `BURST_LEN` (default 4) beats when it is 1. Each rising edge with `brdy_n` low counts one beat on the oldest cycle in flight. The cycle completes on its last beat. `brdy_n` has no effect while no cycle is in flight.
- R7: No more than `MAX_OUT` (2) cycles are in flight. A low `nxt_n` has no effect while `MAX_OUT` cycles are in flight.
- R8: `req_ready` is 0 while a request is waiting or while `MAX_OUT` cycles are in flight, and 1 otherwise.
- R9: A waiting request with no token and with cycles in flight is not started. It starts at the edge after the in-flight count reaches zero.
- R10: A held token is dropped at any edge where no cycle is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | AW | Request address |
| req_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_burst | input | 1 | 1 = burst (BURST_LEN beats), 0 = single beat |
| ads_n | output | 1 | Active-low address strobe |
| bus_addr | output | AW | Bus address |
| bus_mem | output | 1 | Memory/I/O cycle definition |
| bus_wr | output | 1 | Read/write cycle definition |
| nxt_n | input | 1 | Active-low next-address request |
| brdy_n | input | 1 | Active-low data beat ready |

## Verification
The hardest state to reach from the ports has a waiting request, one cycle in flight and a token still counting down. The outcome then depends on whether the in-flight cycle finishes before or after the two-clock delay ends. A directed trace builds this case on purpose. It takes a token and then completes the only cycle in flight, so that a held token would let a later request start early. Long random runs follow, with frequent `nxt_n` and `brdy_n` pulses and a mix of bursts. They hit the same race many times against a cycle-level model in the bench.

// File: rtl/bus_cycle_issuer_pkg.sv
package bus_cycle_issuer_pkg;
  typedef struct packed {
    logic mem;
    logic wr;
    logic burst;
  } cyc_kind_t;
endpackage

// File: rtl/bci_hold.sv
module bci_hold
  import bus_cycle_issuer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          release_i,
  input  logic [AW-1:0] addr_i,
  input  cyc_kind_t     kind_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output cyc_kind_t     kind_o
);
  logic          valid_d;
  logic          load_en;

  // one waiting entry; take and release never coincide
  always_comb begin
    valid_d = valid_o;
    if (release_i) valid_d = 1'b0;
    if (take)      valid_d = 1'b1;
  end

  assign load_en = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o <= '0;
      kind_o <= '0;
    end else if (load_en) begin
      addr_o <= addr_i;
      kind_o <= kind_i;
    end
  end
endmodule

// File: rtl/bci_na_timer.sv
module bci_na_timer #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic consume,
  input  logic flush,
  output logic fire,
  output logic busy
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DLY);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          open_q, open_d;

  assign fire = (cnt_q == ONE) || open_q;
  assign busy = (cnt_q != '0) || open_q;

  always_comb begin
    cnt_d  = cnt_q;
    open_d = open_q;
    if (flush || consume) begin
      cnt_d  = '0;
      open_d = 1'b0;
    end else if (sample && !busy) begin
      cnt_d = LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) open_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      open_q <= open_d;
    end
  end
endmodule

// File: rtl/bci_tracker.sv
module bci_tracker #(
  parameter int DEPTH     = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       push_burst,
  input  logic                       beat,
  output logic [$clog2(DEPTH+1)-1:0] outst
);
  localparam int OW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(BURST_LEN + 1);
  localparam logic [CW-1:0] ONE_BEAT  = CW'(1);
  localparam logic [CW-1:0] BURST_CNT = CW'(BURST_LEN);

  logic [DEPTH-1:0][CW-1:0] cnt_q, cnt_d;
  logic [OW-1:0]            outst_d, slot_idx;
  logic [CW-1:0]            push_cnt;
  logic                     beat_eff, retire;

  assign beat_eff = beat && (outst != '0);
  assign retire   = beat_eff && (cnt_q[0] == ONE_BEAT);
  assign slot_idx = outst - OW'(retire);
  assign push_cnt = push_burst ? BURST_CNT : ONE_BEAT;
  assign outst_d  = outst + OW'(push) - OW'(retire);

  always_comb begin
    cnt_d = retire ? (cnt_q >> CW) : cnt_q;
    if (beat_eff && !retire) cnt_d[0] = cnt_q[0] - ONE_BEAT;
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (slot_idx == OW'(i))) cnt_d[i] = push_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      outst <= '0;
    end else begin
      cnt_q <= cnt_d;
      outst <= outst_d;
    end
  end
endmodule

// File: rtl/bus_cycle_issuer.sv
module bus_cycle_issuer
  import bus_cycle_issuer_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_OUT   = 2,
  parameter int BURST_LEN = 4,
  parameter int NA_DLY    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_mem,
  input  logic          req_wr,
  input  logic          req_burst,
  output logic          ads_n,
  output logic [AW-1:0] bus_addr,
  output logic          bus_mem,
  output logic          bus_wr,
  input  logic          nxt_n,
  input  logic          brdy_n
);
  localparam int OW = $clog2(MAX_OUT + 1);
  localparam logic [OW-1:0] FULL = OW'(MAX_OUT);

  logic          hold_valid, accept, issue, na_fire, na_busy, na_sample;
  logic [AW-1:0] hold_addr;
  cyc_kind_t     hold_kind, req_kind;
  logic [OW-1:0] outst;
  logic          ads_n_d, bus_mem_d, bus_wr_d;
  logic [AW-1:0] bus_addr_d;

  assign req_kind  = '{mem: req_mem, wr: req_wr, burst: req_burst};
  assign req_ready = !hold_valid && (outst != FULL);
  assign accept    = req_valid && req_ready;
  assign issue     = hold_valid && ((outst == '0) || (na_fire && (outst != FULL)));
  assign na_sample = !nxt_n && (outst != '0) && (outst != FULL) && ads_n;

  bci_hold #(.AW(AW)) u_hold (
    .clk(clk), .rst_n(rst_n), .take(accept), .release_i(issue),
    .addr_i(req_addr), .kind_i(req_kind),
    .valid_o(hold_valid), .addr_o(hold_addr), .kind_o(hold_kind)
  );

  bci_na_timer #(.DLY(NA_DLY)) u_na (
    .clk(clk), .rst_n(rst_n), .sample(na_sample), .consume(issue),
    .flush(outst == '0), .fire(na_fire), .busy(na_busy)
  );

  bci_tracker #(.DEPTH(MAX_OUT), .BURST_LEN(BURST_LEN)) u_trk (
    .clk(clk), .rst_n(rst_n), .push(issue), .push_burst(hold_kind.burst),
    .beat(!brdy_n), .outst(outst)
  );

  always_comb begin
    ads_n_d    = !issue;
    bus_addr_d = bus_addr;
    bus_mem_d  = bus_mem;
    bus_wr_d   = bus_wr;
    if (issue) begin
      bus_addr_d = hold_addr;
      bus_mem_d  = hold_kind.mem;
      bus_wr_d   = hold_kind.wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ads_n    <= 1'b1;
      bus_addr <= '0;
      bus_mem  <= 1'b0;
      bus_wr   <= 1'b0;
    end else begin
      ads_n    <= ads_n_d;
      bus_addr <= bus_addr_d;
      bus_mem  <= bus_mem_d;
      bus_wr   <= bus_wr_d;
    end
  end
endmodule

// File: rtl/bus_cycle_issuer_chk.sv
module bus_cycle_issuer_chk #(
  parameter int AW      = 32,
  parameter int MAX_OUT = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         ads_n,
  input logic                         req_ready,
  input logic [AW-1:0]                bus_addr,
  input logic                         bus_mem,
  input logic                         bus_wr,
  input logic [$clog2(MAX_OUT+1)-1:0] outst
);
  localparam int OW = $clog2(MAX_OUT + 1);
  localparam logic [OW-1:0] FULL = OW'(MAX_OUT);

  p_ads_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ads_n |=> ads_n);

  p_def_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ads_n |-> ($stable(bus_addr) && $stable(bus_mem) && $stable(bus_wr)));

  p_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= FULL);

  p_start_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ads_n) |-> ($past(outst) != FULL));

  p_ready_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (outst == FULL) |-> !req_ready);
endmodule

bind bus_cycle_issuer bus_cycle_issuer_chk #(.AW(AW), .MAX_OUT(MAX_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .req_ready(req_ready),
  .bus_addr(bus_addr), .bus_mem(bus_mem), .bus_wr(bus_wr), .outst(outst)
);

// File: tb/test_bus_cycle_issuer.sv
module test_bus_cycle_issuer;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_mem = 1'b0, req_wr = 1'b0, req_burst = 1'b0;
  logic nxt_n = 1'b1, brdy_n = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, ads_n, bus_mem, bus_wr;
  logic [AW-1:0] bus_addr;
  int checks = 0, errors = 0;
  bit cmp_on = 0, done = 0;

  always #5 clk = ~clk;

  bus_cycle_issuer i_bus_cycle_issuer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mem(req_mem), .req_wr(req_wr), .req_burst(req_burst),
    .ads_n(ads_n), .bus_addr(bus_addr), .bus_mem(bus_mem), .bus_wr(bus_wr),
    .nxt_n(nxt_n), .brdy_n(brdy_n)
  );

  // cycle model built from the requirements
  int m_out, m_q0, m_q1, m_cnt;
  bit m_open, m_pend, m_pmem, m_pwr, m_pbur, m_ads_n, m_mem, m_wr;
  logic [AW-1:0] m_paddr, m_addr;

  function automatic bit m_ready();
    return !m_pend && (m_out != 2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_q0 = 0; m_q1 = 0; m_cnt = 0; m_open = 0; m_pend = 0;
      m_ads_n = 1; m_addr = '0; m_mem = 0; m_wr = 0;
    end else begin
      bit fire, iss, ret, take, acc, beat;
      int n;
      fire = (m_cnt == 1) || m_open;
      iss  = m_pend && (m_out == 0 || (fire && m_out < 2));
      beat = !brdy_n && m_out > 0;
      ret  = beat && m_q0 == 1;
      take = !nxt_n && m_out != 0 && m_out < 2 && !(m_cnt != 0 || m_open) && m_ads_n;
      acc  = req_valid && m_ready();
      if (m_out == 0 || iss) begin m_cnt = 0; m_open = 0; end
      else if (take) m_cnt = 2;
      else if (m_cnt != 0) begin if (m_cnt == 1) m_open = 1; m_cnt--; end
      if (beat && !ret) m_q0--;
      if (ret) begin m_q0 = m_q1; m_q1 = 0; end
      n = m_out - (ret ? 1 : 0);
      if (iss) begin
        if (n == 0) m_q0 = m_pbur ? 4 : 1; else m_q1 = m_pbur ? 4 : 1;
        m_addr = m_paddr; m_mem = m_pmem; m_wr = m_pwr; m_pend = 0;
      end
      m_out = n + (iss ? 1 : 0);
      m_ads_n = !iss;
      if (acc) begin
        m_pend = 1; m_paddr = req_addr; m_pmem = req_mem; m_pwr = req_wr; m_pbur = req_burst;
      end
    end
  end

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R2 R3 R5 R6 R7 R9 R10 ads_n", AW'(ads_n), AW'(m_ads_n));
    chk("R8 req_ready", AW'(req_ready), AW'(m_ready()));
    chk("R4 bus_addr", bus_addr, m_addr);
    chk("R4 bus_mem/bus_wr", AW'({bus_mem, bus_wr}), AW'({m_mem, m_wr}));
  end

  task automatic put(input bit v, input logic [AW-1:0] a, input bit mem, input bit wr, input bit bur);
    req_valid = v; req_addr = a; req_mem = mem; req_wr = wr; req_burst = bur;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1 ads_n in reset", AW'(ads_n), 1);
    rst_n = 1'b1;
    @(negedge clk);                                   // n0
    cmp_on = 1;
    chk("R1 ads_n", AW'(ads_n), 1);
    chk("R1 req_ready", AW'(req_ready), 1);
    chk("R1 bus_addr", bus_addr, 0);
    put(1, 32'h100, 1, 0, 0);
    @(negedge clk); put(0, 0, 0, 0, 0);               // n1
    @(negedge clk);                                   // n2
    chk("R2 ads_n after accept", AW'(ads_n), 0);
    chk("R4 address with strobe", bus_addr, 32'h100);
    @(negedge clk);                                   // n3
    chk("R3 ads_n one clock", AW'(ads_n), 1);
    put(1, 32'h200, 0, 1, 1);
    @(negedge clk);                                   // n4
    chk("R8 ready low with waiting request", AW'(req_ready), 0);
    put(0, 0, 0, 0, 0); nxt_n = 1'b0;
    @(negedge clk); nxt_n = 1'b1;                     // n5
    @(negedge clk);                                   // n6
    chk("R5 no strobe one clock after next-address", AW'(ads_n), 1);
    @(negedge clk);                                   // n7
    chk("R5 strobe two clocks after next-address", AW'(ads_n), 0);
    chk("R4 I/O write definition", AW'({bus_mem, bus_wr}), AW'(2'b01));
    chk("R7 ready low at two in flight", AW'(req_ready), 0);
    nxt_n = 1'b0;
    @(negedge clk);                                   // n8
    @(negedge clk); nxt_n = 1'b1;                     // n9
    chk("R7 next-address ignored when full", AW'(ads_n), 1);
    @(negedge clk);                                   // n10
    chk("R7 still no strobe", AW'(ads_n), 1);
    brdy_n = 1'b0;
    @(negedge clk); brdy_n = 1'b1;                    // n11
    chk("R8 ready after one completes", AW'(req_ready), 1);
    put(1, 32'h300, 1, 0, 0);
    @(negedge clk); put(0, 0, 0, 0, 0);               // n12
    repeat (2) @(negedge clk);                        // n14
    chk("R9 waiting request held back", AW'(ads_n), 1);
    brdy_n = 1'b0;
    repeat (3) @(negedge clk);                        // n17
    chk("R4 address held during burst", bus_addr, 32'h200);
    @(negedge clk); brdy_n = 1'b1;                    // n18
    chk("R6 burst needs four beats", AW'(ads_n), 1);
    @(negedge clk);                                   // n19
    chk("R9 start once pipeline empty", AW'(ads_n), 0);
    chk("R9 address", bus_addr, 32'h300);
    @(negedge clk); nxt_n = 1'b0;                     // n20
    @(negedge clk); nxt_n = 1'b1; brdy_n = 1'b0;      // n21
    @(negedge clk); brdy_n = 1'b1;                    // n22
    @(negedge clk); put(1, 32'h400, 1, 1, 0);         // n23
    @(negedge clk); put(0, 0, 0, 0, 0);               // n24
    @(negedge clk); put(1, 32'h500, 1, 0, 0);         // n25
    @(negedge clk); put(0, 0, 0, 0, 0);               // n26
    @(negedge clk);                                   // n27
    chk("R10 dropped token gives no early start", AW'(ads_n), 1);
    @(negedge clk);
    chk("R10 still waiting", AW'(ads_n), 1);
    brdy_n = 1'b0;
    @(negedge clk); brdy_n = 1'b1;
    repeat (3) @(negedge clk);
    brdy_n = 1'b0;
    @(negedge clk); brdy_n = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4000; k++) begin
      put(($urandom % 2) == 0, $urandom, $urandom % 2, $urandom % 2, ($urandom % 10) < 3);
      nxt_n  = ($urandom % 4) != 0;
      brdy_n = ($urandom % 5) < 3;
      @(negedge clk);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule